// File: doc/BRIEF.md
# Debug Hit Privilege Qualifier

This block takes raw debug matches and decides whether they count. An instruction breakpoint hit requires the fetch address to equal a breakpoint address register at word granularity. A data watchpoint hit requires the data address to equal a watchpoint address register at doubleword granularity. Both then pass through filters on the current execution state before they are reported. The breakpoint is filtered by a two-bit privilege selector. The watchpoint is filtered by three per-state enable bits and by a check on whether the access was translated.

A qualified watchpoint is reported as a data-storage fault. It carries its own status code and latches the faulting data address. A qualified breakpoint is reported as a trace-class event with its own status code. The core's exception logic consumes both. Outputs are registered and at most one hit is reported per cycle. When both qualify together, the watchpoint goes out first and the breakpoint is held for a later cycle.

Top module: `dbg_hit_qualifier`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `bp_hit` and `wp_hit` are 0, both status vectors are all zero and `wp_fault_addr` is zero.
- R2: A fetch can raise a breakpoint only when `fetch_valid` is 1 and `fetch_addr` equals `bp_addr` with address bits [1:0] ignored.
- R3: The current state is problem state when `mode_prob` is 1. Otherwise it is hypervisor state when `mode_hyp` is 1, and supervisor state when neither is set. The two-bit `bp_priv` has four encodings. 0 never qualifies. 1 qualifies only in problem state. 2 qualifies only when `mode_prob` and `mode_hyp` are both 0. 3 qualifies only when `mode_prob` is 0 and `mode_hyp` is 1.
- R4: An access can raise a watchpoint only when `data_valid` is 1 and `data_addr` equals `wp_addr` with address bits [2:0] ignored.
- R5: A watchpoint qualifies only if the enable bit for the current state (R3) is set. That bit is `wp_en_prob`, `wp_en_sup` or `wp_en_hyp`.
- R6: When `wp_xlat_ign` is 0, a watchpoint qualifies only if `mode_reloc` equals `wp_xlat`. A translated access therefore needs `wp_xlat`=1, and an untranslated access needs `wp_xlat`=0.
- R7: When `wp_xlat_ign` is 1, the values of `mode_reloc` and `wp_xlat` have no effect on the watchpoint result.
- R8: In a cycle where a watchpoint is reported, `wp_status` has only bit 41 set (value 1<<41, with bit 0 as the least significant bit). In the same cycle `wp_fault_addr` holds the `data_addr` of the qualifying access. `wp_fault_addr` keeps that value until the next reported watchpoint. `wp_status` is zero in any cycle without a reported watchpoint.
- R9: In a cycle where a breakpoint is reported, `bp_status` has exactly bits 33 and 43 set (value (1<<33)|(1<<43)). It is zero in any cycle without a reported breakpoint.
- R10: A hit is reported one cycle after the qualifying inputs, and at most one of `bp_hit`/`wp_hit` is 1 in any cycle. Each cycle gives priority in this order: a newly qualified watchpoint first, then a held breakpoint, then a newly qualified breakpoint. A breakpoint that loses is held. Breakpoints held at the same time merge into one report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_prob | input | 1 | Problem (user) state |
| mode_hyp | input | 1 | Hypervisor state |
| mode_reloc | input | 1 | Data accesses are translated |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_addr | input | ADDR_W | Instruction fetch address |
| bp_addr | input | ADDR_W | Breakpoint address register |
| bp_priv | input | 2 | Breakpoint privilege selector |
| data_valid | input | 1 | Data access valid this cycle |
| data_addr | input | ADDR_W | Data access address |
| wp_addr | input | ADDR_W | Watchpoint address register |
| wp_en_prob | input | 1 | Watchpoint enabled in problem state |
| wp_en_sup | input | 1 | Watchpoint enabled in supervisor state |
| wp_en_hyp | input | 1 | Watchpoint enabled in hypervisor state |
| wp_xlat | input | 1 | Required translation mode |
| wp_xlat_ign | input | 1 | Ignore translation mode |
| bp_hit | output | 1 | Qualified breakpoint reported |
| bp_status | output | STATUS_W | Breakpoint status code |
| wp_hit | output | 1 | Qualified watchpoint reported |
| wp_status | output | STATUS_W | Watchpoint status code |
| wp_fault_addr | output | ADDR_W | Latched faulting data address |

## Verification
The bench builds the block with its defaults. These are 64-bit addresses, 64-bit status vectors, two ignored low bits for breakpoints and three for watchpoints. With these values, offsets inside the ignored low bits reach a hit, and the first offset above them misses. Random stimulus copies the register address into the access address about half the time and flips random low bits. It randomizes mode and control bits, so every privilege encoding, state enable and translation case is reached. Back-to-back collisions exercise the held-breakpoint ordering and merging.

// File: rtl/dbg_qual_pkg.sv
`timescale 1ns/1ps
package dbg_qual_pkg;
   typedef enum logic [1:0] {
      PRIV_OFF  = 2'd0,
      PRIV_PROB = 2'd1,
      PRIV_SUP  = 2'd2,
      PRIV_HYP  = 2'd3
   } priv_sel_e;

   localparam int BP_CODE_LO = 33;
   localparam int BP_CODE_HI = 43;
   localparam int WP_CODE    = 41;
endpackage

// File: rtl/dbg_addr_match.sv
`timescale 1ns/1ps
module dbg_addr_match #(
   parameter int ADDR_W = 64,
   parameter int IGN    = 3
) (
   input  logic              valid,
   input  logic [ADDR_W-1:0] addr_a,
   input  logic [ADDR_W-1:0] addr_b,
   output logic              hit
);
   initial begin
      if (IGN < 0 || IGN >= ADDR_W) $error("dbg_addr_match: IGN out of range");
   end

   generate
      if (IGN == 0) begin : g_exact
         assign hit = valid && (addr_a == addr_b);
      end else begin : g_masked
         localparam logic [ADDR_W-1:0] CMP_MASK = ~((ADDR_W'(1) << IGN) - ADDR_W'(1));
         assign hit = valid && (((addr_a ^ addr_b) & CMP_MASK) == '0);
      end
   endgenerate
endmodule

// File: rtl/dbg_bp_qual.sv
`timescale 1ns/1ps
module dbg_bp_qual
   import dbg_qual_pkg::*;
(
   input  logic       addr_hit,
   input  logic [1:0] priv,
   input  logic       mode_prob,
   input  logic       mode_hyp,
   output logic       qual
);
   priv_sel_e sel;
   logic      state_ok;

   assign sel = priv_sel_e'(priv);

   always_comb begin
      unique case (sel)
         PRIV_PROB: state_ok = mode_prob;
         PRIV_SUP:  state_ok = !mode_prob && !mode_hyp;
         PRIV_HYP:  state_ok = !mode_prob && mode_hyp;
         default:   state_ok = 1'b0;
      endcase
   end

   assign qual = addr_hit && state_ok;
endmodule

// File: rtl/dbg_wp_qual.sv
`timescale 1ns/1ps
module dbg_wp_qual (
   input  logic addr_hit,
   input  logic en_prob,
   input  logic en_sup,
   input  logic en_hyp,
   input  logic xlat,
   input  logic xlat_ign,
   input  logic mode_prob,
   input  logic mode_hyp,
   input  logic mode_reloc,
   output logic qual
);
   logic state_ok;
   logic xlat_ok;

   always_comb begin
      if (mode_prob)     state_ok = en_prob;
      else if (mode_hyp) state_ok = en_hyp;
      else               state_ok = en_sup;
   end

   assign xlat_ok = xlat_ign || (mode_reloc == xlat);
   assign qual    = addr_hit && state_ok && xlat_ok;
endmodule

// File: rtl/dbg_hit_qualifier.sv
`timescale 1ns/1ps
module dbg_hit_qualifier
   import dbg_qual_pkg::*;
#(
   parameter int ADDR_W   = 64,
   parameter int STATUS_W = 64,
   parameter int BP_IGN   = 2,
   parameter int WP_IGN   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mode_prob,
   input  logic                mode_hyp,
   input  logic                mode_reloc,
   input  logic                fetch_valid,
   input  logic [ADDR_W-1:0]   fetch_addr,
   input  logic [ADDR_W-1:0]   bp_addr,
   input  logic [1:0]          bp_priv,
   input  logic                data_valid,
   input  logic [ADDR_W-1:0]   data_addr,
   input  logic [ADDR_W-1:0]   wp_addr,
   input  logic                wp_en_prob,
   input  logic                wp_en_sup,
   input  logic                wp_en_hyp,
   input  logic                wp_xlat,
   input  logic                wp_xlat_ign,
   output logic                bp_hit,
   output logic [STATUS_W-1:0] bp_status,
   output logic                wp_hit,
   output logic [STATUS_W-1:0] wp_status,
   output logic [ADDR_W-1:0]   wp_fault_addr
);
   localparam logic [STATUS_W-1:0] BP_CODE =
      (STATUS_W'(1) << BP_CODE_LO) | (STATUS_W'(1) << BP_CODE_HI);
   localparam logic [STATUS_W-1:0] WP_CODE_V = STATUS_W'(1) << WP_CODE;

   initial begin
      if (STATUS_W <= BP_CODE_HI) $error("dbg_hit_qualifier: STATUS_W too small");
      if (ADDR_W <= WP_IGN || ADDR_W <= BP_IGN) $error("dbg_hit_qualifier: ADDR_W too small");
   end

   logic bp_addr_hit, wp_addr_hit;
   logic bp_q, wp_q;
   logic bp_pend;
   logic bp_go;

   dbg_addr_match #(.ADDR_W(ADDR_W), .IGN(BP_IGN)) u_bp_match (
      .valid (fetch_valid),
      .addr_a(fetch_addr),
      .addr_b(bp_addr),
      .hit   (bp_addr_hit)
   );

   dbg_addr_match #(.ADDR_W(ADDR_W), .IGN(WP_IGN)) u_wp_match (
      .valid (data_valid),
      .addr_a(data_addr),
      .addr_b(wp_addr),
      .hit   (wp_addr_hit)
   );

   dbg_bp_qual u_bp_qual (
      .addr_hit (bp_addr_hit),
      .priv     (bp_priv),
      .mode_prob(mode_prob),
      .mode_hyp (mode_hyp),
      .qual     (bp_q)
   );

   dbg_wp_qual u_wp_qual (
      .addr_hit  (wp_addr_hit),
      .en_prob   (wp_en_prob),
      .en_sup    (wp_en_sup),
      .en_hyp    (wp_en_hyp),
      .xlat      (wp_xlat),
      .xlat_ign  (wp_xlat_ign),
      .mode_prob (mode_prob),
      .mode_hyp  (mode_hyp),
      .mode_reloc(mode_reloc),
      .qual      (wp_q)
   );

   // A breakpoint goes out when no new watchpoint claims the cycle.
   assign bp_go = !wp_q && (bp_pend || bp_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bp_hit        <= 1'b0;
         wp_hit        <= 1'b0;
         bp_status     <= '0;
         wp_status     <= '0;
         wp_fault_addr <= '0;
         bp_pend       <= 1'b0;
      end else begin
         wp_hit    <= wp_q;
         bp_hit    <= bp_go;
         wp_status <= wp_q  ? WP_CODE_V : '0;
         bp_status <= bp_go ? BP_CODE   : '0;
         if (wp_q) begin
            wp_fault_addr <= data_addr;
            bp_pend       <= bp_pend || bp_q;
         end else begin
            bp_pend       <= bp_pend && bp_q;
         end
      end
   end
endmodule

// File: rtl/dbg_hit_qualifier_chk.sv
`timescale 1ns/1ps
module dbg_hit_qualifier_chk #(
   parameter int ADDR_W   = 64,
   parameter int STATUS_W = 64
) (
   input logic                clk,
   input logic                rst_n,
   input logic                data_valid,
   input logic [ADDR_W-1:0]   data_addr,
   input logic                bp_hit,
   input logic [STATUS_W-1:0] bp_status,
   input logic                wp_hit,
   input logic [STATUS_W-1:0] wp_status,
   input logic [ADDR_W-1:0]   wp_fault_addr
);
   localparam logic [STATUS_W-1:0] BP_EXP = (STATUS_W'(1) << 33) | (STATUS_W'(1) << 43);
   localparam logic [STATUS_W-1:0] WP_EXP = STATUS_W'(1) << 41;

   // R10
   hits_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bp_hit, wp_hit}));
   // R8
   wp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wp_hit |-> (wp_status == WP_EXP));
   // R8
   wp_idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wp_hit |-> (wp_status == '0));
   // R9
   bp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bp_hit |-> (bp_status == BP_EXP));
   // R9
   bp_idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bp_hit |-> (bp_status == '0));
   // R8
   fault_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wp_hit |-> (wp_fault_addr == $past(data_addr)));
   // R8
   fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wp_hit |-> $stable(wp_fault_addr));
   // R4
   wp_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wp_hit |-> $past(data_valid));
endmodule

bind dbg_hit_qualifier dbg_hit_qualifier_chk #(.ADDR_W(ADDR_W), .STATUS_W(STATUS_W)) u_chk (.*);

// File: tb/dbg_hit_qualifier_bench.sv
`timescale 1ns/1ps
module dbg_hit_qualifier_bench;
   localparam int AW = 64;
   localparam int SW = 64;
   localparam logic [SW-1:0] BP_EXP = (SW'(1) << 33) | (SW'(1) << 43);
   localparam logic [SW-1:0] WP_EXP = SW'(1) << 41;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_prob = 0, mode_hyp = 0, mode_reloc = 0;
   logic fetch_valid = 0, data_valid = 0;
   logic [AW-1:0] fetch_addr = '0, bp_addr = '0, data_addr = '0, wp_addr = '0;
   logic [1:0] bp_priv = 2'd0;
   logic wp_en_prob = 0, wp_en_sup = 0, wp_en_hyp = 0, wp_xlat = 0, wp_xlat_ign = 0;
   logic bp_hit, wp_hit;
   logic [SW-1:0] bp_status, wp_status;
   logic [AW-1:0] wp_fault_addr;

   int n_chk = 0;
   int n_err = 0;
   logic m_pend = 1'b0;
   logic [AW-1:0] m_fault = '0;

   always #5 clk = ~clk;

   dbg_hit_qualifier u_dbg_hit_qualifier (.*);

   function automatic logic bp_ok();
      if (!fetch_valid || fetch_addr[AW-1:2] != bp_addr[AW-1:2]) return 1'b0;
      case (bp_priv)
         2'd1:    return mode_prob;
         2'd2:    return !mode_prob && !mode_hyp;
         2'd3:    return !mode_prob && mode_hyp;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic wp_ok();
      logic en;
      if (!data_valid || data_addr[AW-1:3] != wp_addr[AW-1:3]) return 1'b0;
      en = mode_prob ? wp_en_prob : (mode_hyp ? wp_en_hyp : wp_en_sup);
      if (!en) return 1'b0;
      if (!wp_xlat_ign && (mode_reloc != wp_xlat)) return 1'b0;
      return 1'b1;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle();
      fetch_valid = 0; data_valid = 0;
   endtask

   // Inputs are already set; advance one clock and compare registered outputs.
   task automatic cycle(input string tag);
      logic bq, wq, e_bp, e_wp;
      bq = bp_ok();
      wq = wp_ok();
      e_wp = wq;
      e_bp = !wq && (m_pend || bq);
      if (wq) begin
         m_fault = data_addr;
         m_pend  = m_pend || bq;
      end else begin
         m_pend  = m_pend && bq;
      end
      @(posedge clk);
      @(negedge clk);
      chk({bp_hit, wp_hit} == {e_bp, e_wp}, tag, AW'({bp_hit, wp_hit}), AW'({e_bp, e_wp}));
      chk(bp_status == (e_bp ? BP_EXP : '0), {tag, " R9 status"}, bp_status, e_bp ? BP_EXP : '0);
      chk(wp_status == (e_wp ? WP_EXP : '0), {tag, " R8 status"}, wp_status, e_wp ? WP_EXP : '0);
      chk(wp_fault_addr == m_fault, {tag, " R8 addr"}, wp_fault_addr, m_fault);
   endtask

   initial begin
      #1_000_000;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({bp_hit, wp_hit} == 2'b00, "R1 hits", AW'({bp_hit, wp_hit}), '0);
      chk(bp_status == '0 && wp_status == '0, "R1 status", AW'(bp_status | wp_status), '0);
      chk(wp_fault_addr == '0, "R1 addr", wp_fault_addr, '0);
      rst_n = 1'b1;
      cycle("R1 first cycle");

      // R2 word match, R3 problem encoding
      bp_addr = 64'h0000_1234_5678_9A00; bp_priv = 2'd1; mode_prob = 1;
      fetch_valid = 1; fetch_addr = bp_addr | 64'h3; cycle("R2 low bits ignored");
      fetch_addr = bp_addr ^ 64'h4;                  cycle("R2 bit2 differs");
      fetch_valid = 0; fetch_addr = bp_addr;         cycle("R2 not valid");
      // R3 encodings
      fetch_valid = 1;
      bp_priv = 2'd0;                                cycle("R3 priv0 off");
      bp_priv = 2'd2; mode_prob = 1;                 cycle("R3 sup in prob");
      mode_prob = 0; mode_hyp = 0;                   cycle("R3 sup hit");
      mode_hyp = 1;                                  cycle("R3 sup in hyp");
      bp_priv = 2'd3;                                cycle("R3 hyp hit");
      mode_prob = 1;                                 cycle("R3 hyp with prob");
      bp_priv = 2'd1; mode_hyp = 0; mode_prob = 0;   cycle("R3 prob in sup");
      idle();

      // R4 doubleword match
      wp_addr = 64'h0000_00FF_0000_1000; mode_prob = 0; mode_hyp = 0;
      wp_en_sup = 1; wp_xlat_ign = 1; data_valid = 1;
      data_addr = wp_addr | 64'h7;                   cycle("R4 low bits ignored");
      data_addr = wp_addr ^ 64'h8;                   cycle("R4 bit3 differs R8 hold");
      data_valid = 0; data_addr = wp_addr;           cycle("R4 not valid");
      data_valid = 1;
      // R5 state enables
      wp_en_sup = 0;                                 cycle("R5 sup disabled");
      mode_prob = 1; wp_en_prob = 1;                 cycle("R5 prob enabled");
      wp_en_prob = 0; wp_en_hyp = 1;                 cycle("R5 prob disabled");
      mode_prob = 0; mode_hyp = 1;                   cycle("R5 hyp enabled");
      // R6 translation check
      wp_xlat_ign = 0; mode_reloc = 1; wp_xlat = 0;  cycle("R6 translated needs xlat");
      wp_xlat = 1;                                   cycle("R6 translated match");
      mode_reloc = 0;                                cycle("R6 untranslated mismatch");
      wp_xlat = 0;                                   cycle("R6 untranslated match");
      // R7 ignore
      wp_xlat_ign = 1; mode_reloc = 1; wp_xlat = 0;  cycle("R7 ignored a");
      mode_reloc = 0; wp_xlat = 1;                   cycle("R7 ignored b");
      idle();                                        cycle("R8 hold idle");

      // R10 collision: watchpoint first, breakpoint held
      mode_prob = 0; mode_hyp = 1; bp_priv = 2'd3; fetch_addr = bp_addr;
      fetch_valid = 1; data_valid = 1; data_addr = wp_addr + 64'h2;
      cycle("R10 collision");
      idle();                                        cycle("R10 held bp out");
      fetch_valid = 1; data_valid = 1;               cycle("R10 collision two");
                                                     cycle("R10 merge");
      data_valid = 0;                                cycle("R10 held then new");
      idle();                                        cycle("R10 drain");
      cycle("R10 quiet");

      // Random phase (R2..R10)
      for (int i = 0; i < 4000; i++) begin
         bp_addr     = {$urandom, $urandom};
         wp_addr     = {$urandom, $urandom};
         fetch_addr  = ($urandom % 2) ? (bp_addr ^ AW'($urandom % 8)) : {$urandom, $urandom};
         data_addr   = ($urandom % 2) ? (wp_addr ^ AW'($urandom % 16)) : {$urandom, $urandom};
         fetch_valid = ($urandom % 4) != 0;
         data_valid  = ($urandom % 4) != 0;
         bp_priv     = 2'($urandom);
         {mode_prob, mode_hyp, mode_reloc} = 3'($urandom);
         {wp_en_prob, wp_en_sup, wp_en_hyp, wp_xlat, wp_xlat_ign} = 5'($urandom);
         cycle("R10 random");
      end
      idle();
      cycle("R10 final drain");

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule